// File: doc/BRIEF.md
# Low-Voltage Detect Status and Control Register

This block is an 8-bit register that software reaches over a simple strobe bus. It sits between a supply comparator and the rest of the chip. The comparator gives a synchronous low-supply indication. The register turns that indication into a sticky detect flag. From the flag it raises a level interrupt request and a level reset request. Software chooses which of these actions are active, and each action also depends on a master enable bit. A separate stop-mode enable bit decides whether detection keeps running while the chip is in stop mode.

Software clears the flag by writing 1 to an acknowledge bit. That bit holds no state and always reads as 0. The master enable, the stop-mode enable and the reset enable are protected by a write-once lock. The first bus write after reset loads them and sets the lock, and later writes cannot change them. The interrupt enable stays writable at all times. The comparator, the threshold logic and the chip's reset generator are outside this block.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After reset, a read returns 0x1C: reset enable (bit 4), stop-mode enable (bit 3) and master enable (bit 2) are 1; flag (bit 7) and interrupt enable (bit 5) are 0; both request outputs are 0.
- R2: Read data bits 1:0 and bit 6 (acknowledge) always read as 0, and writing to bits 1:0 has no effect on any state.
- R3: A low-supply input sampled high at a clock edge while the master enable is 1 sets the flag at that edge. While the master enable is 0, the flag is never set.
- R4: The flag stays at 1 after the low-supply input returns low, until it is acknowledged.
- R5: A write with bit 6 set clears the flag at that edge. If a qualified detect happens in the same cycle, the flag stays at 1.
- R6: The interrupt enable (bit 5) can be written on every write. The interrupt request is a register that equals the AND of the flag and the interrupt enable from the previous cycle.
- R7: The reset request is a register that equals the AND of the flag, the reset enable and the master enable from the previous cycle.
- R8: The first write after reset loads bits 4:2. Every later write leaves bits 4:2 unchanged until the next reset.
- R9: While the stop-mode input is high, detect events set the flag only if both the stop-mode enable and the master enable are 1.
- R10: Read data is 0 whenever the read strobe is low. While the strobe is high, read data shows the register image combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, zero when rdEn is low |
| lowVolt | input | 1 | Synchronous low-supply indication from the comparator |
| stopMode | input | 1 | High while the chip is in stop mode |
| irqReq | output | 1 | Level interrupt request |
| rstReq | output | 1 | Level reset request |

## Verification
The assertions assume that lowVolt, stopMode and the bus strobes are synchronous to clk and are stable around each rising edge. The assertions also assume that every cycle with wrEn high is one complete write. The write-once check keeps its own record of whether a write has happened since reset and does not rely on the design's lock. The bench drives every input on the falling edge and holds each write for exactly one cycle. It applies reset again before each scenario that needs a fresh lock. This keeps each configuration bit pattern reachable, and it keeps the stimulus within the single-write-per-strobe assumption.

// File: rtl/lvd_reg_pkg.sv
package lvd_reg_pkg;

  localparam int REG_W    = 8;
  localparam int FLAG_BIT = 7;
  localparam int ACK_BIT  = 6;
  localparam int IEN_BIT  = 5;
  localparam int REN_BIT  = 4;
  localparam int SEN_BIT  = 3;
  localparam int MEN_BIT  = 2;

  localparam logic [REG_W-1:0] RESET_IMAGE =
    REG_W'((1 << REN_BIT) | (1 << SEN_BIT) | (1 << MEN_BIT));

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic loadIntEn;
    logic loadCfg;
  } lvdStrobes_t;

endpackage

// File: rtl/lvd_reg_ctrl.sv
module lvd_reg_ctrl
  import lvd_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        ackBit,
  input  logic        lowVolt,
  input  logic        stopMode,
  input  logic        masterEn,
  input  logic        stopEn,
  output lvdStrobes_t strobes
);

  logic cfgLocked;
  logic detectOk;

  // Any write closes the configuration window until the next reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgLocked <= 1'b0;
    else if (wrEn) cfgLocked <= 1'b1;
  end

  // Detection requires the master enable. In stop mode it also requires the stop-mode enable.
  assign detectOk = lowVolt & masterEn & (~stopMode | stopEn);

  always_comb begin
    strobes.setFlag   = detectOk;
    strobes.clrFlag   = wrEn & ackBit;
    strobes.loadIntEn = wrEn;
    strobes.loadCfg   = wrEn & ~cfgLocked;
  end

endmodule

// File: rtl/lvd_reg_datapath.sv
module lvd_reg_datapath
  import lvd_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lvdStrobes_t      strobes,
  input  logic             wrIntEn,
  input  logic             wrRstEn,
  input  logic             wrStopEn,
  input  logic             wrMasterEn,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  output logic             flag,
  output logic             intEn,
  output logic             rstEn,
  output logic             stopEn,
  output logic             masterEn,
  output logic             irqReq,
  output logic             rstReq
);

  logic [REG_W-1:0] image;

  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flag <= 1'b0;
    else if (strobes.setFlag)  flag <= 1'b1;
    else if (strobes.clrFlag)  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  intEn <= RESET_IMAGE[IEN_BIT];
    else if (strobes.loadIntEn) intEn <= wrIntEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstEn    <= RESET_IMAGE[REN_BIT];
      stopEn   <= RESET_IMAGE[SEN_BIT];
      masterEn <= RESET_IMAGE[MEN_BIT];
    end else if (strobes.loadCfg) begin
      rstEn    <= wrRstEn;
      stopEn   <= wrStopEn;
      masterEn <= wrMasterEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      irqReq <= flag & intEn;
      rstReq <= flag & rstEn & masterEn;
    end
  end

  always_comb begin
    image           = '0;
    image[FLAG_BIT] = flag;
    image[IEN_BIT]  = intEn;
    image[REN_BIT]  = rstEn;
    image[SEN_BIT]  = stopEn;
    image[MEN_BIT]  = masterEn;
  end

  assign rdData = rdEn ? image : '0;

endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdEn,
  output logic [REG_W-1:0] rdData,
  input  logic             lowVolt,
  input  logic             stopMode,
  output logic             irqReq,
  output logic             rstReq
);

  lvdStrobes_t strobes;
  logic flag, intEn, rstEn, stopEn, masterEn;
  logic unusedWrBits;

  assign unusedWrBits = ^{wrData[FLAG_BIT], wrData[1:0]};

  lvd_reg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .ackBit   (wrData[ACK_BIT]),
    .lowVolt  (lowVolt),
    .stopMode (stopMode),
    .masterEn (masterEn),
    .stopEn   (stopEn),
    .strobes  (strobes)
  );

  lvd_reg_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrIntEn    (wrData[IEN_BIT]),
    .wrRstEn    (wrData[REN_BIT]),
    .wrStopEn   (wrData[SEN_BIT]),
    .wrMasterEn (wrData[MEN_BIT]),
    .rdEn       (rdEn),
    .rdData     (rdData),
    .flag       (flag),
    .intEn      (intEn),
    .rstEn      (rstEn),
    .stopEn     (stopEn),
    .masterEn   (masterEn),
    .irqReq     (irqReq),
    .rstReq     (rstReq)
  );

endmodule

// File: rtl/lvd_ctrl_reg_chk.sv
module lvd_ctrl_reg_chk
  import lvd_reg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic             rdEn,
  input logic [REG_W-1:0] rdData,
  input logic             lowVolt,
  input logic             stopMode,
  input logic             irqReq,
  input logic             rstReq,
  input logic             flag,
  input logic             intEn,
  input logic             rstEn,
  input logic             stopEn,
  input logic             masterEn
);

  logic sawWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sawWrite <= 1'b0;
    else if (wrEn) sawWrite <= 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[1:0] == 2'b00 && rdData[ACK_BIT] == 1'b0);

  // R3
  master_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!masterEn && !flag) |=> !flag);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !(wrEn && wrData[ACK_BIT])) |=> flag);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowVolt && masterEn && !stopMode) |=> flag);

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqReq == $past(flag && intEn)));

  // R7
  rst_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rstReq == $past(flag && rstEn && masterEn)));

  // R8
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    sawWrite |=> ($stable(rstEn) && $stable(stopEn) && $stable(masterEn)));

  // R9
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopMode && !stopEn && !flag) |=> !flag);

  // R10
  read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == '0);

endmodule

bind lvd_ctrl_reg lvd_ctrl_reg_chk u_chk (.*);

// File: tb/lvd_ctrl_reg_bench.sv
module lvd_ctrl_reg_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrData;
  logic       rdEn;
  logic [7:0] rdData;
  logic       lowVolt;
  logic       stopMode;
  logic       irqReq;
  logic       rstReq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvd_ctrl_reg u_lvd_ctrl_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .lowVolt(lowVolt), .stopMode(stopMode),
    .irqReq(irqReq), .rstReq(rstReq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0; lowVolt = 1'b0; stopMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(output logic [7:0] d);
    rdEn = 1'b1;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic pulseLow();
    lowVolt = 1'b1;
    @(negedge clk);
    lowVolt = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] r;
    doReset();
    check(rdData, 8'h00, "R10 idle read bus");
    busRead(r);
    check(r, 8'h1C, "R1 reset image");
    check({6'b0, irqReq, rstReq}, 8'h00, "R1 requests low");
  endtask

  task automatic testDetect();
    logic [7:0] r;
    doReset();
    pulseLow();
    busRead(r);
    check(r, 8'h9C, "R3 flag set");
    check({7'b0, rstReq}, 8'h00, "R7 request registered");
    @(negedge clk);
    check({7'b0, rstReq}, 8'h01, "R7 reset request");
    check({7'b0, irqReq}, 8'h00, "R6 no irq when disabled");
    repeat (3) @(negedge clk);
    busRead(r);
    check(r, 8'h9C, "R4 flag sticky");
  endtask

  task automatic testAckAndLock();
    logic [7:0] r;
    busWrite(8'h7C);
    busRead(r);
    check(r, 8'h3C, "R5 ack clears flag, R6 intEn set");
    @(negedge clk);
    check({6'b0, irqReq, rstReq}, 8'h00, "R7 requests drop");
    busWrite(8'h00);
    busRead(r);
    check(r, 8'h1C, "R8 cfg kept, intEn cleared");
    busWrite(8'h20);
    busRead(r);
    check(r, 8'h3C, "R6 intEn rewritable");
  endtask

  task automatic testSameCycle();
    logic [7:0] r;
    lowVolt = 1'b1;
    busWrite(8'h7C);
    lowVolt = 1'b0;
    busRead(r);
    check(r, 8'hBC, "R5 set wins over ack");
    @(negedge clk);
    check({7'b0, irqReq}, 8'h01, "R6 irq asserted");
    busWrite(8'h7C);
    busRead(r);
    check(r, 8'h3C, "R5 later ack clears");
    @(negedge clk);
    check({7'b0, irqReq}, 8'h00, "R6 irq drops");
  endtask

  task automatic testMasterOff();
    logic [7:0] r;
    doReset();
    busWrite(8'h18);
    pulseLow();
    @(negedge clk);
    busRead(r);
    check(r, 8'h18, "R3 masterEn off blocks flag");
    check({7'b0, rstReq}, 8'h00, "R3 no reset request");
    busWrite(8'h1C);
    busRead(r);
    check(r, 8'h18, "R8 second write ignored");
  endtask

  task automatic testStop();
    logic [7:0] r;
    doReset();
    busWrite(8'h14);
    stopMode = 1'b1;
    pulseLow();
    busRead(r);
    check(r, 8'h14, "R9 stop blocks detect");
    stopMode = 1'b0;
    pulseLow();
    busRead(r);
    check(r, 8'h94, "R9 run mode detects");
    doReset();
    stopMode = 1'b1;
    pulseLow();
    stopMode = 1'b0;
    busRead(r);
    check(r, 8'h9C, "R9 stop detect when enabled");
  endtask

  task automatic testNoReset();
    logic [7:0] r;
    doReset();
    busWrite(8'h0F);
    busRead(r);
    check(r, 8'h0C, "R2 bits 1:0 ignored");
    pulseLow();
    @(negedge clk);
    @(negedge clk);
    check({7'b0, rstReq}, 8'h00, "R7 rstEn off");
    check(rdData, 8'h00, "R10 no read strobe");
    busWrite(8'h03);
    busRead(r);
    check(r, 8'h8C, "R2 reserved write no effect");
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0; lowVolt = 1'b0; stopMode = 1'b0;
    testReset();
    testDetect();
    testAckAndLock();
    testSameCycle();
    testMasterOff();
    testStop();
    testNoReset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule